// File: doc/BRIEF.md
# Chopped-Converter Calibration and Averaging Datapath

This block post-processes the decimated words that one sigma-delta converter channel produces. Because the converter swaps its inputs on alternate conversions, consecutive filter words carry an offset of alternating sign. The block adds each new word to the word before it and halves the sum, and only that pair average reaches the result register. Before it is stored, the average is corrected: the offset coefficient is subtracted first, and the remainder is then multiplied by an unsigned fixed-point gain coefficient. The gain value at mid-range stands for 1.0. The product saturates to the output width.

A mode command selects continuous conversion, stop, or one of four calibrations. The calibrations are zero-scale or full-scale, each with internal or external (system) inputs. A zero-scale calibration stores its averaged word as the new offset. A full-scale calibration computes the gain that maps the corrected full-scale input onto the largest output code. It does this with a sequential divider. Factory coefficients are loaded at reset. A ready flag marks every new result and every finished calibration. While a calibration runs, the block forces the filter's rate request to its slowest setting and, for internal calibrations, asks the input selector for the internal zero or full-scale source.

States: `ST_IDLE` (no conversion), `ST_CONV_PRIME` (waiting for the first word of a conversion run), `ST_CONV_RUN` (one result per word), `ST_CAL_PRIME` (first calibration word), `ST_CAL_TAKE` (second calibration word, capture), `ST_GAIN_DIV` (gain division running). Transitions: any mode write goes to `ST_CONV_PRIME`, `ST_CAL_PRIME` or `ST_IDLE` according to the command and the enable bit. A word moves PRIME to RUN or to TAKE. A word in TAKE goes to `ST_IDLE`, or to `ST_GAIN_DIV` when a full-scale division is needed. Division done goes to `ST_IDLE`.

Top module: `cal_chop_dp`

## Requirements
- R1: In continuous mode, every accepted word after the first of a run writes result = corrected value of floor((previous word + current word) / 2), visible the cycle after the word. result changes at no other time.
- R2: After any mode write, the first accepted word produces no result and no ready. The first result follows the second word.
- R3: Correction is max(0, avg − offset) × gain / 2^(GW−1), truncated. The offset is subtracted before the multiplication, and the value saturates to 2^DW−1.
- R4: During and after reset: result = 0, ready = 0, offset_q = DEF_OFF, gain_q = DEF_GAIN, in_sel = 0, filt_rate = rate_sel.
- R5: mode_cmd encoding: 0 stop, 1 continuous, 4 internal zero-scale, 5 internal full-scale, 6 system zero-scale, 7 system full-scale; 2 and 3 act as stop. Bit 0 selects full-scale and bit 1 selects system. In_sel is 1 during an internal zero-scale calibration and 2 during an internal full-scale one, and 0 otherwise. Words are ignored while stopped.
- R6: A mode write with conv_en = 0 stops the block. No conversion runs, and the coefficients and ready are left unchanged afterwards, apart from ready being cleared.
- R7: A zero-scale calibration writes the average of its two words into offset_q and sets ready, both visible the cycle after the second word. It then stops.
- R8: A full-scale calibration sets gain_q = min(2^GW−1, floor((2^DW−1)·2^(GW−1) / (avg − offset_q))) using the offset currently held, whether or not a zero-scale calibration has run since reset. If avg ≤ offset_q, gain_q becomes 2^GW−1 after one cycle. Otherwise gain_q and ready appear DW+GW cycles after the second word's edge.
- R9: filt_rate equals all ones while a calibration is in progress, from the mode write until completion. Otherwise it equals rate_sel.
- R10: ready is cleared by a mode write, which takes precedence over everything else. Otherwise a new result or a finished calibration sets it, and otherwise rd_result clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_valid | input | 1 | Filter word strobe |
| fw_data | input | DW | Filter word, unsigned |
| mode_wr | input | 1 | Mode command write strobe |
| mode_cmd | input | 3 | Mode command code |
| conv_en | input | 1 | Converter enable, sampled with mode_wr |
| rate_sel | input | RW | Requested filter update rate |
| rd_result | input | 1 | Result read strobe, clears ready |
| result | output | DW | Corrected averaged result |
| ready | output | 1 | Result or calibration complete |
| offset_q | output | DW | Offset coefficient register |
| gain_q | output | GW | Gain coefficient register, 1.0 = 2^(GW−1) |
| filt_rate | output | RW | Rate request to the filter |
| in_sel | output | 2 | Input source request: 0 pins, 1 internal zero, 2 internal full |

## Verification
The bench builds the block with DW = 12, GW = 12 and RW = 4, a nonzero factory offset of 8 and unity gain. At these widths the 23-step gain division finishes within a short wait, and realistic word values reach both the saturated gain and the saturated result. A gain computed from 4000/4002 words lands just above unity, so full-scale words then overflow the output. Words below the captured offset exercise the clamp to zero. A second reset followed by a full-scale calibration shows the factory offset being used in the gain computation.

// File: rtl/cal_dp_pkg.sv
package cal_dp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV_PRIME,
        ST_CONV_RUN,
        ST_CAL_PRIME,
        ST_CAL_TAKE,
        ST_GAIN_DIV
    } cal_state_e;

    localparam logic [2:0] MD_STOP   = 3'd0;
    localparam logic [2:0] MD_CONT   = 3'd1;
    localparam logic [2:0] MD_ZS_INT = 3'd4;
    localparam logic [2:0] MD_FS_INT = 3'd5;
    localparam logic [2:0] MD_ZS_SYS = 3'd6;
    localparam logic [2:0] MD_FS_SYS = 3'd7;

    localparam logic [1:0] SRC_PINS = 2'd0;
    localparam logic [1:0] SRC_ZERO = 2'd1;
    localparam logic [1:0] SRC_FULL = 2'd2;

    function automatic logic is_cal_state(cal_state_e s);
        return (s == ST_CAL_PRIME) || (s == ST_CAL_TAKE) || (s == ST_GAIN_DIV);
    endfunction

endpackage

// File: rtl/cal_pair_avg.sv
module cal_pair_avg #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] avg
);
    logic [DW-1:0] prev_q;
    logic [DW:0]   sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (load) begin
            prev_q <= cur;
        end
    end

    // chop offsets of opposite sign cancel in the pair sum
    always_comb begin
        sum = {1'b0, prev_q} + {1'b0, cur};
        avg = sum[DW:1];
    end
endmodule

// File: rtl/cal_offset_gain.sv
module cal_offset_gain #(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 16
) (
    input  logic [DW-1:0] avg,
    input  logic [DW-1:0] offset,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] corrected
);
    localparam int unsigned PW = DW + GW;
    localparam logic [PW-1:0] MAX_OUT = PW'({DW{1'b1}});

    logic [DW:0]   diff;
    logic [DW-1:0] mag;
    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;

    always_comb begin
        diff = {1'b0, avg} - {1'b0, offset};
        mag  = diff[DW] ? '0 : diff[DW-1:0];
        prod = PW'(mag) * PW'(gain);
        shifted = prod >> (GW - 1);
        if (shifted > MAX_OUT) begin
            corrected = '1;
        end else begin
            corrected = shifted[DW-1:0];
        end
    end
endmodule

// File: rtl/cal_gain_div.sv
module cal_gain_div #(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [GW-1:0] quo
);
    localparam int unsigned NW = DW + GW - 1;
    localparam int unsigned CW = $clog2(NW + 1);
    localparam logic [NW-1:0] NUMER = {{DW{1'b1}}, {(GW-1){1'b0}}};

    logic [DW:0]   rem_q;
    logic [NW-1:0] num_q;
    logic [NW-1:0] q_q;
    logic [DW-1:0] dv_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    logic [DW:0]   trial;
    logic          fits;
    logic [DW:0]   rem_n;

    always_comb begin
        trial = {rem_q[DW-1:0], num_q[NW-1]};
        fits  = trial >= {1'b0, dv_q};
        rem_n = fits ? (trial - {1'b0, dv_q}) : trial;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            num_q  <= '0;
            q_q    <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            num_q  <= NUMER;
            q_q    <= '0;
            dv_q   <= divisor;
            cnt_q  <= CW'(NW);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                rem_q <= rem_n;
                num_q <= {num_q[NW-2:0], 1'b0};
                q_q   <= {q_q[NW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        done = busy_q && (cnt_q == '0);
        quo  = (|q_q[NW-1:GW]) ? '1 : q_q[GW-1:0];
    end
endmodule

// File: rtl/cal_chop_dp.sv
module cal_chop_dp
    import cal_dp_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 16,
    parameter int unsigned RW = 4,
    parameter logic [DW-1:0] DEF_OFF  = '0,
    parameter logic [GW-1:0] DEF_GAIN = {1'b1, {(GW-1){1'b0}}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_valid,
    input  logic [DW-1:0] fw_data,
    input  logic          mode_wr,
    input  logic [2:0]    mode_cmd,
    input  logic          conv_en,
    input  logic [RW-1:0] rate_sel,
    input  logic          rd_result,
    output logic [DW-1:0] result,
    output logic          ready,
    output logic [DW-1:0] offset_q,
    output logic [GW-1:0] gain_q,
    output logic [RW-1:0] filt_rate,
    output logic [1:0]    in_sel
);
    cal_state_e state_q, state_d;
    logic       cal_full_q;
    logic       cal_int_q;

    logic          word_take;
    logic          pair_load;
    logic [DW-1:0] avg;
    logic [DW-1:0] corrected;
    logic [DW:0]   span;
    logic          span_pos;
    logic          div_start;
    logic          div_done;
    logic [GW-1:0] div_quo;

    logic          ev_result;
    logic          ev_offset;
    logic          ev_gain_max;
    logic          ev_gain_div;
    logic          set_rdy;

    assign word_take = fw_valid && !mode_wr;
    assign pair_load = word_take && (state_q != ST_IDLE) && (state_q != ST_GAIN_DIV);

    cal_pair_avg #(.DW(DW)) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pair_load),
        .cur   (fw_data),
        .avg   (avg)
    );

    cal_offset_gain #(.DW(DW), .GW(GW)) u_corr (
        .avg       (avg),
        .offset    (offset_q),
        .gain      (gain_q),
        .corrected (corrected)
    );

    always_comb begin
        span     = {1'b0, avg} - {1'b0, offset_q};
        span_pos = !span[DW] && (span != '0);
    end

    assign div_start = (state_q == ST_CAL_TAKE) && word_take && cal_full_q && span_pos;

    cal_gain_div #(.DW(DW), .GW(GW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .divisor (span[DW-1:0]),
        .done    (div_done),
        .quo     (div_quo)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            if (!conv_en) begin
                state_d = ST_IDLE;
            end else begin
                unique case (mode_cmd)
                    MD_CONT:   state_d = ST_CONV_PRIME;
                    MD_ZS_INT,
                    MD_FS_INT,
                    MD_ZS_SYS,
                    MD_FS_SYS: state_d = ST_CAL_PRIME;
                    default:   state_d = ST_IDLE;
                endcase
            end
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_CONV_PRIME: if (fw_valid) state_d = ST_CONV_RUN;
                ST_CONV_RUN:   state_d = ST_CONV_RUN;
                ST_CAL_PRIME:  if (fw_valid) state_d = ST_CAL_TAKE;
                ST_CAL_TAKE:   if (fw_valid) state_d = span_pos && cal_full_q ? ST_GAIN_DIV : ST_IDLE;
                ST_GAIN_DIV:   if (div_done) state_d = ST_IDLE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cal_full_q <= 1'b0;
            cal_int_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mode_wr) begin
                cal_full_q <= mode_cmd[0];
                cal_int_q  <= ~mode_cmd[1];
            end
        end
    end

    // datapath events
    always_comb begin
        ev_result   = 1'b0;
        ev_offset   = 1'b0;
        ev_gain_max = 1'b0;
        ev_gain_div = 1'b0;
        unique case (state_q)
            ST_CONV_RUN: ev_result = word_take;
            ST_CAL_TAKE: begin
                ev_offset   = word_take && !cal_full_q;
                ev_gain_max = word_take && cal_full_q && !span_pos;
            end
            ST_GAIN_DIV: ev_gain_div = div_done && !mode_wr;
            default: ;
        endcase
        set_rdy = ev_result || ev_offset || ev_gain_max || ev_gain_div;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            ready    <= 1'b0;
            offset_q <= DEF_OFF;
            gain_q   <= DEF_GAIN;
        end else begin
            if (ev_result)   result   <= corrected;
            if (ev_offset)   offset_q <= avg;
            if (ev_gain_max) gain_q   <= '1;
            if (ev_gain_div) gain_q   <= div_quo;
            if (mode_wr) begin
                ready <= 1'b0;
            end else if (set_rdy) begin
                ready <= 1'b1;
            end else if (rd_result) begin
                ready <= 1'b0;
            end
        end
    end

    // rate and source requests
    always_comb begin
        filt_rate = rate_sel;
        in_sel    = SRC_PINS;
        if (is_cal_state(state_q)) begin
            filt_rate = '1;
            if (cal_int_q) begin
                in_sel = cal_full_q ? SRC_FULL : SRC_ZERO;
            end
        end
    end
endmodule

// File: rtl/cal_chop_dp_chk.sv
module cal_chop_dp_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned GW = 16,
    parameter int unsigned RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fw_valid,
    input logic          mode_wr,
    input logic          conv_en,
    input logic [DW-1:0] result,
    input logic          ready,
    input logic [DW-1:0] offset_q,
    input logic [GW-1:0] gain_q,
    input logic [RW-1:0] filt_rate,
    input logic [1:0]    in_sel
);
    // R10
    mode_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !ready);

    // R9
    cal_slow_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel != 2'd0) |-> (filt_rate == {RW{1'b1}}));

    // R6
    disabled_keeps_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !conv_en) |=> ($stable(offset_q) && $stable(gain_q)));

    // R7
    offset_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_q) |-> $past(fw_valid));

    // R1
    result_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($past(fw_valid) && !$past(mode_wr)));

    // R5
    src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_sel != 2'd3);
endmodule

bind cal_chop_dp cal_chop_dp_chk #(.DW(DW), .GW(GW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_valid  (fw_valid),
    .mode_wr   (mode_wr),
    .conv_en   (conv_en),
    .result    (result),
    .ready     (ready),
    .offset_q  (offset_q),
    .gain_q    (gain_q),
    .filt_rate (filt_rate),
    .in_sel    (in_sel)
);

// File: tb/cal_chop_dp_tb.sv
module cal_chop_dp_tb;
    localparam int PERIOD = 10;
    localparam int DW = 12;
    localparam int GW = 12;
    localparam int RW = 4;
    localparam longint MAXO = (1 << DW) - 1;
    localparam longint MAXG = (1 << GW) - 1;
    localparam longint UNITY = 1 << (GW - 1);
    localparam int NW = DW + GW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fw_valid = 1'b0;
    logic [DW-1:0] fw_data = '0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_cmd = '0;
    logic          conv_en = 1'b0;
    logic [RW-1:0] rate_sel = 4'd3;
    logic          rd_result = 1'b0;
    logic [DW-1:0] result;
    logic          ready;
    logic [DW-1:0] offset_q;
    logic [GW-1:0] gain_q;
    logic [RW-1:0] filt_rate;
    logic [1:0]    in_sel;

    int total = 0;
    int bad = 0;
    bit started = 0;

    cal_chop_dp #(.DW(DW), .GW(GW), .RW(RW), .DEF_OFF(12'd8), .DEF_GAIN(12'h800)) u_dut (
        .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_data(fw_data),
        .mode_wr(mode_wr), .mode_cmd(mode_cmd), .conv_en(conv_en), .rate_sel(rate_sel),
        .rd_result(rd_result), .result(result), .ready(ready), .offset_q(offset_q),
        .gain_q(gain_q), .filt_rate(filt_rate), .in_sel(in_sel)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference: 0 stop,1 conv prime,2 conv run,3 cal prime,4 cal take,5 gain wait
    int     m_st;
    longint m_prev, m_res, m_off, m_gain, m_pend;
    bit     m_rdy, m_full, m_int;
    int     m_wait;

    function automatic longint corr(longint a, longint off, longint g);
        longint d, s;
        d = a - off;
        if (d < 0) d = 0;
        s = (d * g) >>> (GW - 1);
        if (s > MAXO) s = MAXO;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_prev = 0; m_res = 0; m_off = 8; m_gain = UNITY;
            m_rdy = 0; m_full = 0; m_int = 0; m_wait = 0; m_pend = 0;
        end else if (mode_wr) begin
            m_rdy = 0;
            m_full = mode_cmd[0];
            m_int = !mode_cmd[1];
            if (!conv_en) m_st = 0;
            else if (mode_cmd == 3'd1) m_st = 1;
            else if (mode_cmd >= 3'd4) m_st = 3;
            else m_st = 0;
        end else begin
            bit   s;
            longint a;
            s = 0;
            a = (m_prev + longint'(fw_data)) / 2;
            case (m_st)
                1: if (fw_valid) begin m_prev = fw_data; m_st = 2; end
                2: if (fw_valid) begin m_res = corr(a, m_off, m_gain); m_prev = fw_data; s = 1; end
                3: if (fw_valid) begin m_prev = fw_data; m_st = 4; end
                4: if (fw_valid) begin
                    m_prev = fw_data;
                    if (!m_full) begin m_off = a; s = 1; m_st = 0; end
                    else if (a - m_off <= 0) begin m_gain = MAXG; s = 1; m_st = 0; end
                    else begin
                        m_pend = (MAXO * UNITY) / (a - m_off);
                        if (m_pend > MAXG) m_pend = MAXG;
                        m_wait = NW; m_st = 5;
                    end
                end
                5: if (m_wait == 0) begin m_gain = m_pend; s = 1; m_st = 0; end
                   else m_wait--;
                default: ;
            endcase
            if (s) m_rdy = 1;
            else if (rd_result) m_rdy = 0;
        end
        started = 1;
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (started) begin
            bit cal;
            cal = (m_st >= 3);
            chk(result == m_res[DW-1:0], "R1 result", result, m_res);
            chk(ready == m_rdy, "R10 ready", ready, m_rdy);
            chk(offset_q == m_off[DW-1:0], "R7 offset", offset_q, m_off);
            chk(gain_q == m_gain[GW-1:0], "R8 gain", gain_q, m_gain);
            chk(filt_rate == (cal ? 4'hF : rate_sel), "R9 rate", filt_rate, cal ? 15 : rate_sel);
            chk(in_sel == ((cal && m_int) ? (m_full ? 2 : 1) : 0), "R5 in_sel", in_sel,
                (cal && m_int) ? (m_full ? 2 : 1) : 0);
        end
    end

    task automatic cmd(logic [2:0] m, logic en);
        @(negedge clk);
        mode_wr = 1; mode_cmd = m; conv_en = en;
        @(negedge clk);
        mode_wr = 0;
    endtask

    task automatic word(int d);
        @(negedge clk);
        fw_valid = 1; fw_data = DW'(d);
        @(negedge clk);
        fw_valid = 0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_result = 1;
        @(negedge clk);
        rd_result = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        // R4 reset values
        chk(result == 0 && ready == 0, "R4 reset result/ready", {result, ready}, 0);
        chk(offset_q == 8 && gain_q == 2048, "R4 reset coef", offset_q, 8);
        chk(filt_rate == 3 && in_sel == 0, "R4 reset rate/src", filt_rate, 3);
        rst_n = 1;
        idle(2);

        // R2 and R1 continuous conversion
        cmd(3'd1, 1);
        word(100);
        chk(ready == 0, "R2 first word no ready", ready, 0);
        word(200);
        chk(result == 142 && ready == 1, "R1 first average", result, 142);
        word(300);
        chk(result == 242, "R1 running average", result, 242);
        rd();
        chk(ready == 0, "R10 read clears ready", ready, 0);
        idle(2);
        chk(ready == 0, "R10 stays clear", ready, 0);

        // R7 internal zero-scale, R9 slow rate, R5 source
        cmd(3'd4, 1);
        chk(filt_rate == 15 && in_sel == 1, "R9 cal rate / R5 zero src", filt_rate, 15);
        word(20);
        word(22);
        chk(offset_q == 21 && ready == 1, "R7 offset captured", offset_q, 21);
        chk(filt_rate == 3, "R9 rate restored", filt_rate, 3);

        // R8 system full-scale
        cmd(3'd7, 1);
        chk(in_sel == 0 && filt_rate == 15, "R5 system full src", in_sel, 0);
        word(4000);
        word(4002);
        idle(NW - 3);
        chk(gain_q == 2048 && ready == 0, "R8 gain not yet", gain_q, 2048);
        idle(5);
        chk(gain_q == 2107 && ready == 1, "R8 gain computed", gain_q, 2107);

        // R3 clamp and saturation
        cmd(3'd1, 1);
        word(10);
        word(20);
        chk(result == 0, "R3 below offset clamps", result, 0);
        word(4095);
        word(4095);
        chk(result == 4095, "R3 saturation", result, 4095);

        // R6 disabled calibration
        cmd(3'd6, 0);
        word(500);
        word(502);
        chk(offset_q == 21 && ready == 0, "R6 no capture when disabled", offset_q, 21);

        // R5 reserved code behaves as stop
        cmd(3'd2, 1);
        word(1000);
        word(1000);
        chk(result == 4095 && ready == 0, "R5 reserved ignores words", result, 4095);

        // R8 low span gives max gain, R5 internal full source
        cmd(3'd5, 1);
        chk(in_sel == 2, "R5 internal full src", in_sel, 2);
        word(10);
        word(12);
        chk(gain_q == 4095 && ready == 1, "R8 low span max gain", gain_q, 4095);

        // R2 restart, R10 mode write clears
        cmd(3'd1, 1);
        word(100);
        cmd(3'd1, 1);
        word(200);
        chk(ready == 0, "R2 restart needs two words", ready, 0);
        word(300);
        chk(ready == 1, "R2 result after restart", ready, 1);
        cmd(3'd0, 1);
        chk(ready == 0, "R10 mode write clears", ready, 0);

        // R8 full-scale with factory offset after fresh reset
        @(negedge clk); rst_n = 0;
        idle(2);
        chk(offset_q == 8 && gain_q == 2048, "R4 coef reloaded", gain_q, 2048);
        rst_n = 1;
        cmd(3'd7, 1);
        word(4000);
        word(4002);
        idle(NW + 4);
        chk(gain_q == 2100, "R8 gain with factory offset", gain_q, 2100);

        idle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule